// File: doc/BRIEF.md
# Serial Audio Frame Interface

This block is the synchronous serial port between a 16-bit audio converter core and a DSP. The DSP supplies a bit clock and a frame sync. Each frame is 32 bit-clock periods long. The first 16 periods form a data slot that carries one two's-complement sample in each direction, most significant bit first. The remaining 16 periods form an empty slot. The capture sample from the converter goes out on the serial data output, and the playback sample arriving on the serial data input is collected into a parallel word with a one-cycle valid strobe.

Two framings are supported. In long framing, the frame sync is high through the start of the data slot, and its rising edge marks bit 15. In short framing, the frame sync is a single bit-clock pulse, and bit 15 follows on the next bit-clock period. The framing lives in a one-bit mode register. At reset this register takes the inverse of a strap pin: a low strap selects short framing and a high strap selects long framing. The surrounding register file can later overwrite the mode through a load strobe.

The block runs on a fast system clock. The bit clock, frame sync and serial input pass through a synchronizer, and the block detects the bit-clock edges in that domain. The bit clock must be slow enough that each of its half-periods spans at least three system-clock cycles.

Top module: `safi_port`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `sdo` is 0, `rx_valid` is 0 and `rx_sample` is 0.
- R2: During reset the framing mode becomes short (mode 1) when `strap_lvl` is 0, and long (mode 0) when it is 1. A one-cycle `mode_load` pulse replaces the mode with `mode_value` (1 = short, 0 = long).
- R3: In long mode, a bit-clock rising edge at which `fsync` is seen high, after being seen low at the previous rising edge, starts a frame. `sdo` carries `tx_sample[15]` from that edge on, and then bits 14 down to 0 on the next 15 rising edges.
- R4: In short mode, the rising edge that follows the rising edge at which `fsync` was first seen high starts the frame. `sdo` carries bit 15 from there, then bits 14 down to 0 on the following rising edges.
- R5: `sdo` changes only in response to a bit-clock rising edge.
- R6: `sdi` is sampled on bit-clock falling edges during frame slots 0 to 15, most significant bit first, and forms `rx_sample`.
- R7: After the falling edge that captures the last bit (slot 15), `rx_sample` takes the new word and `rx_valid` is high for exactly one system-clock cycle. Outside that update `rx_sample` holds its value.
- R8: In slots 16 to 31, `sdo` is 0 and `sdi` has no effect on `rx_sample`.
- R9: `tx_sample` is captured at the frame-start edge. Later changes to it do not alter the bits sent in the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_lvl | input | 1 | Strap pin level, sampled during reset to pick the default framing |
| mode_load | input | 1 | One-cycle strobe that writes `mode_value` into the mode register |
| mode_value | input | 1 | New framing mode: 1 short, 0 long |
| bclk | input | 1 | Serial bit clock from the DSP |
| fsync | input | 1 | Frame sync from the DSP |
| sdi | input | 1 | Serial playback data from the DSP |
| tx_sample | input | 16 | Parallel capture sample to transmit |
| sdo | output | 1 | Serial capture data to the DSP |
| rx_sample | output | 16 | Last complete received playback sample |
| rx_valid | output | 1 | One-cycle strobe when `rx_sample` updates |

## Verification
A bit-clock edge reaches the logic two system cycles after the pin changes, and `sdo` registers on the third cycle. The bench therefore holds each bit-clock level for four system cycles and samples `sdo` on the falling system-clock edge just before it lowers the bit clock, once per slot. `rx_valid` arrives about three cycles after the slot-15 falling edge. A monitor compares `rx_sample` to the expected word on each strobe, and after each frame the bench checks that exactly one strobe occurred. The expected bits come from bench functions over the random sample words, so the empty slot and the mid-frame change of `tx_sample` are both checked against the word captured at frame start.

// File: rtl/safi_pkg.sv
// Shared constants and types for the serial audio frame interface.
// Assumes a single system clock domain; all serial pins are asynchronous to it.
package safi_pkg;
    localparam int SAMPLE_W_DEF   = 16;
    localparam int FRAME_BITS_DEF = 32;
    localparam int SYNC_DEF       = 2;

    typedef enum logic {
        FRAME_LONG  = 1'b0,
        FRAME_SHORT = 1'b1
    } frame_mode_e;
endpackage

// File: rtl/safi_edge_sync.sv
// Synchronizes bit clock, frame sync and serial input into the system clock
// domain and flags the bit-clock edges. All three pins go through the same
// depth, so they stay aligned with each other.
// Assumes each bit-clock half-period lasts at least STAGES+1 system cycles.
module safi_edge_sync #(
    parameter int STAGES = safi_pkg::SYNC_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic sdi,
    output logic bclk_rise,
    output logic bclk_fall,
    output logic fsync_s,
    output logic sdi_s
);
    localparam int NSIG = 3;

    logic [STAGES-1:0][NSIG-1:0] pipe;
    logic                        bclk_d;

    // First stage catches the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= {sdi, fsync, bclk};
    end

    // Remaining stages, one per extra level of synchronization.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= pipe[g-1];
        end
    end

    // Delayed bit clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= pipe[STAGES-1][0];
    end

    assign bclk_rise = pipe[STAGES-1][0] & ~bclk_d;
    assign bclk_fall = ~pipe[STAGES-1][0] & bclk_d;
    assign fsync_s   = pipe[STAGES-1][1];
    assign sdi_s     = pipe[STAGES-1][2];
endmodule

// File: rtl/safi_frame_seq.sv
// Holds the framing mode and tracks the slot position in the frame.
// The mode register loads the inverted strap level during reset and can be
// overwritten by the register file. The sequencer finds the frame start
// (long: fsync edge at a rising bclk; short: the rising bclk after that)
// and counts slots 0..FRAME_BITS-1. The value FRAME_BITS means idle.
module safi_frame_seq #(
    parameter int FRAME_BITS = safi_pkg::FRAME_BITS_DEF,
    localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_lvl,
    input  logic             mode_load,
    input  logic             mode_value,
    input  logic             bclk_rise,
    input  logic             fsync_s,
    output logic             frame_start,
    output logic [CNT_W-1:0] slot
);
    import safi_pkg::*;

    localparam logic [CNT_W-1:0] IDLE_SLOT = CNT_W'(FRAME_BITS);

    frame_mode_e mode_q;
    logic        fs_prev;
    logic        short_pend;
    logic        fs_edge;

    // Mode register: strap sets the default, the load strobe overrides it.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= strap_lvl ? FRAME_LONG : FRAME_SHORT;
        else if (mode_load) mode_q <= frame_mode_e'(mode_value);
    end

    assign fs_edge     = fsync_s & ~fs_prev;
    assign frame_start = bclk_rise &
                         ((mode_q == FRAME_SHORT) ? short_pend : fs_edge);

    // Frame-sync history, sampled only at bit-clock rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_prev    <= 1'b0;
            short_pend <= 1'b0;
        end else if (bclk_rise) begin
            fs_prev    <= fsync_s;
            short_pend <= fs_edge;
        end
    end

    // Slot counter: restart on frame start, stop at the idle value.
    always_ff @(posedge clk) begin
        if (!rst_n)                          slot <= IDLE_SLOT;
        else if (frame_start)                slot <= '0;
        else if (bclk_rise && slot != IDLE_SLOT) slot <= slot + 1'b1;
    end
endmodule

// File: rtl/safi_tx_shift.sv
// Transmit shifter. Captures the parallel sample at frame start and drives
// it MSB first, one bit per rising bclk. Drives 0 outside the data slot.
// Assumes `slot` is the slot value before the current rising edge updates it.
module safi_tx_shift #(
    parameter int SAMPLE_W   = safi_pkg::SAMPLE_W_DEF,
    parameter int FRAME_BITS = safi_pkg::FRAME_BITS_DEF,
    localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_rise,
    input  logic                frame_start,
    input  logic [CNT_W-1:0]    slot,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic                sdo
);
    localparam logic [CNT_W:0] LAST_DATA = (CNT_W+1)'(SAMPLE_W - 1);

    logic [SAMPLE_W-1:0] shreg;
    logic [CNT_W:0]      slot_next;

    assign slot_next = {1'b0, slot} + 1'b1;

    // Load on frame start, shift on later rising edges while in the data slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            sdo   <= 1'b0;
        end else if (frame_start) begin
            sdo   <= tx_sample[SAMPLE_W-1];
            shreg <= {tx_sample[SAMPLE_W-2:0], 1'b0};
        end else if (bclk_rise) begin
            if (slot_next <= LAST_DATA) begin
                sdo   <= shreg[SAMPLE_W-1];
                shreg <= {shreg[SAMPLE_W-2:0], 1'b0};
            end else begin
                sdo   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/safi_rx_shift.sv
// Receive shifter. Samples the serial input on falling bclk during the data
// slot, MSB first, and publishes the word with a one-cycle strobe after the
// last bit. Ignores the input in the empty slot and while idle.
module safi_rx_shift #(
    parameter int SAMPLE_W   = safi_pkg::SAMPLE_W_DEF,
    parameter int FRAME_BITS = safi_pkg::FRAME_BITS_DEF,
    localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_fall,
    input  logic [CNT_W-1:0]    slot,
    input  logic                sdi_s,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid
);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(SAMPLE_W - 1);

    logic [SAMPLE_W-1:0] shreg;
    logic                in_data;
    logic [SAMPLE_W-1:0] shifted;

    assign in_data = (slot <= LAST_DATA);
    assign shifted = {shreg[SAMPLE_W-2:0], sdi_s};

    // Shift register for the data slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                   shreg <= '0;
        else if (bclk_fall && in_data) shreg <= shifted;
    end

    // Publish the word and raise the strobe once the last bit is in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sample <= '0;
            rx_valid  <= 1'b0;
        end else if (bclk_fall && slot == LAST_DATA) begin
            rx_sample <= shifted;
            rx_valid  <= 1'b1;
        end else begin
            rx_valid  <= 1'b0;
        end
    end
endmodule

// File: rtl/safi_port.sv
// Top of the serial audio frame interface: synchronizer, frame sequencer,
// transmit and receive shifters. Assumes bclk runs at FRAME_BITS times the
// frame rate and each bclk half-period covers at least SYNC_STAGES+1 cycles.
module safi_port #(
    parameter int SAMPLE_W    = safi_pkg::SAMPLE_W_DEF,
    parameter int FRAME_BITS  = safi_pkg::FRAME_BITS_DEF,
    parameter int SYNC_STAGES = safi_pkg::SYNC_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strap_lvl,
    input  logic                mode_load,
    input  logic                mode_value,
    input  logic                bclk,
    input  logic                fsync,
    input  logic                sdi,
    input  logic [SAMPLE_W-1:0] tx_sample,
    output logic                sdo,
    output logic [SAMPLE_W-1:0] rx_sample,
    output logic                rx_valid
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    logic             bclk_rise;
    logic             bclk_fall;
    logic             fsync_s;
    logic             sdi_s;
    logic             frame_start;
    logic [CNT_W-1:0] slot;

    safi_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .fsync     (fsync),
        .sdi       (sdi),
        .bclk_rise (bclk_rise),
        .bclk_fall (bclk_fall),
        .fsync_s   (fsync_s),
        .sdi_s     (sdi_s)
    );

    safi_frame_seq #(.FRAME_BITS(FRAME_BITS)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_lvl   (strap_lvl),
        .mode_load   (mode_load),
        .mode_value  (mode_value),
        .bclk_rise   (bclk_rise),
        .fsync_s     (fsync_s),
        .frame_start (frame_start),
        .slot        (slot)
    );

    safi_tx_shift #(.SAMPLE_W(SAMPLE_W), .FRAME_BITS(FRAME_BITS)) tx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_rise   (bclk_rise),
        .frame_start (frame_start),
        .slot        (slot),
        .tx_sample   (tx_sample),
        .sdo         (sdo)
    );

    safi_rx_shift #(.SAMPLE_W(SAMPLE_W), .FRAME_BITS(FRAME_BITS)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_fall (bclk_fall),
        .slot      (slot),
        .sdi_s     (sdi_s),
        .rx_sample (rx_sample),
        .rx_valid  (rx_valid)
    );
endmodule

// File: rtl/safi_port_chk.sv
// Property checker for safi_port, attached with the bind below.
// Observes the edge flags, slot counter and outputs.
module safi_port_chk #(
    parameter int SAMPLE_W   = 16,
    parameter int FRAME_BITS = 32,
    localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bclk_rise,
    input logic                bclk_fall,
    input logic [CNT_W-1:0]    slot,
    input logic                sdo,
    input logic [SAMPLE_W-1:0] rx_sample,
    input logic                rx_valid
);
    // R5: sdo moves only after a detected rising bit-clock edge.
    a_r5_sdo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_rise |=> $stable(sdo));

    // R7: the strobe lasts one cycle.
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7: the strobe follows a falling bit-clock edge.
    a_r7_valid_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bclk_fall));

    // R7: the received word holds between strobes.
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_sample));

    // R8: the empty slot and the idle state drive sdo low.
    a_r8_quiet_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (slot >= CNT_W'(SAMPLE_W)) |-> !sdo);

    // R1: outputs are clear on the cycle after reset.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!sdo && !rx_valid && rx_sample == '0));
endmodule

bind safi_port safi_port_chk #(.SAMPLE_W(SAMPLE_W), .FRAME_BITS(FRAME_BITS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .slot      (slot),
    .sdo       (sdo),
    .rx_sample (rx_sample),
    .rx_valid  (rx_valid)
);

// File: tb/safi_port_tb_top.sv
// Bench for safi_port: plays the DSP side with random sample words and
// directed corner cases, and checks against expected values from functions.
module safi_port_tb_top;
    localparam int SW   = 16;
    localparam int FB   = 32;
    localparam int HALF = 4;      // system cycles per bclk half-period

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strap_lvl = 1'b0;
    logic          mode_load = 1'b0;
    logic          mode_value = 1'b0;
    logic          bclk = 1'b0;
    logic          fsync = 1'b0;
    logic          sdi = 1'b0;
    logic [SW-1:0] tx_sample = '0;
    logic          sdo;
    logic [SW-1:0] rx_sample;
    logic          rx_valid;

    int unsigned   n_checks = 0;
    int unsigned   n_fail   = 0;
    int unsigned   n_strobe = 0;
    logic [SW-1:0] exp_rx   = '0;
    bit            finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    safi_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_lvl  (strap_lvl),
        .mode_load  (mode_load),
        .mode_value (mode_value),
        .bclk       (bclk),
        .fsync      (fsync),
        .sdi        (sdi),
        .tx_sample  (tx_sample),
        .sdo        (sdo),
        .rx_sample  (rx_sample),
        .rx_valid   (rx_valid)
    );

    // Expected serial bit for a slot: MSB first in the data slot, 0 after.
    function automatic logic exp_sdo_bit(input logic [SW-1:0] w, input int s);
        return (s < SW) ? w[SW-1-s] : 1'b0;
    endfunction

    task automatic check(input string tag, input logic [SW-1:0] act,
                         input logic [SW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R6/R7 monitor: every strobe must carry the expected word.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            n_strobe++;
            check("R6 rx_sample at strobe", rx_sample, exp_rx);
        end
    end

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        strap_lvl = strap;
        repeat (4) @(negedge clk);
        check("R1 sdo in reset", {15'd0, sdo}, '0);
        check("R1 rx_valid in reset", {15'd0, rx_valid}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rx_sample after reset", rx_sample, '0);
        check("R1 sdo after reset", {15'd0, sdo}, '0);
    endtask

    task automatic load_mode(input logic m);
        @(negedge clk);
        mode_load = 1'b1;
        mode_value = m;
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    // One DSP frame. short_m selects the framing the bench plays.
    task automatic run_frame(input logic short_m, input logic [SW-1:0] tx,
                             input logic [SW-1:0] rxw, input logic [SW-1:0] tail,
                             input bit swap_tx);
        int unsigned strobes_before;
        string tag;
        tag = short_m ? "R4 short-frame sdo" : "R3 long-frame sdo";
        tx_sample = tx;
        exp_rx = rxw;
        strobes_before = n_strobe;
        if (short_m) begin
            bclk = 1'b1; fsync = 1'b1; sdi = 1'($urandom);
            half_wait();
            bclk = 1'b0;
            half_wait();
        end
        for (int s = 0; s < FB; s++) begin
            bclk  = 1'b1;
            fsync = short_m ? 1'b0 : (s < FB/2);
            sdi   = (s < SW) ? rxw[SW-1-s] : tail[s-SW];
            half_wait();
            if (s < SW)
                check(swap_tx ? "R9 sdo after tx change" : tag,
                      {15'd0, sdo}, {15'd0, exp_sdo_bit(tx, s)});
            else
                check("R8 empty slot sdo", {15'd0, sdo}, '0);
            if (s == 3 && swap_tx) tx_sample = ~tx;
            bclk = 1'b0;
            half_wait();
        end
        check("R7 one strobe per frame", SW'(n_strobe - strobes_before), SW'(1));
        check("R8 rx_sample after empty slot", rx_sample, rxw);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5AF1));
        // R2: strap low -> short framing by default.
        do_reset(1'b0);
        run_frame(1'b1, 16'h8001, 16'hA55A, 16'hFFFF, 1'b0);
        run_frame(1'b1, 16'h7FFE, 16'h0000, 16'hFFFF, 1'b0);
        // R2: strap high -> long framing by default.
        do_reset(1'b1);
        run_frame(1'b0, 16'hFFFF, 16'h8000, 16'h0000, 1'b0);
        run_frame(1'b0, 16'h0000, 16'h7FFF, 16'hFFFF, 1'b0);
        // R9: tx change in the middle of the data slot.
        run_frame(1'b0, 16'hC3A5, 16'h1234, 16'h5555, 1'b1);
        // R2: mode_load switches to short, then back to long.
        load_mode(1'b1);
        run_frame(1'b1, 16'h1357, 16'hFEDC, 16'hAAAA, 1'b1);
        load_mode(1'b0);
        run_frame(1'b0, 16'h2468, 16'h0F0F, 16'h3C3C, 1'b0);
        // Random frames with random mode changes.
        for (int i = 0; i < 40; i++) begin
            logic m;
            m = 1'($urandom);
            load_mode(m);
            run_frame(m, 16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule